// File: doc/BRIEF.md
# Split-Transaction Completion Timeout Tracker

This block watches non-posted requests that are waiting for completions and reports any that stay open longer than a programmable period. Each request carries a tag. When the request handshake fires, the block marks that tag as outstanding and starts a countdown for it. A completion with the same tag closes the entry. If the countdown reaches zero first, the block does one of two things. With resend enabled, it asks for the request to be sent again. Otherwise it reports a timeout error and frees the tag.

Timing comes from one prescaled tick that all entries share. The period is a tick count picked by a small code, so one design can serve platforms whose completion latency ranges from a few ticks up to very long waits. Detection can be switched off. While it is off, every timer holds its value, but tags are still opened and closed.

A capability-version input chooses where the controls come from. In the first variant, enable, resend and period all come from a writable control register. In the second variant, enable and period come from configuration-space fields, and resend comes from a read-only bit loaded at initialization. Whichever source is in use, the block mirrors the effective values onto read-only status outputs.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: After reset the status outputs show detection enabled (`sts_disable_o`=0), resend off (`sts_resend_o`=0) and period code 0. No strobe is active.
- R2: The period for code c is P=BASE_TICKS<<c ticks, and one tick occurs every TICK_DIV cycles. An unanswered request produces its expiry strobe between (P-1)*TICK_DIV+1 and P*TICK_DIV+2 cycles after the clock edge that sampled it. With the default parameters and code 0, that is between 113 and 130 cycles.
- R3: A completion whose tag is outstanding closes that entry. No strobe ever follows for it.
- R4: A completion whose tag is not outstanding changes no state. It raises `unexp_cpl_o` for one cycle, visible right after the edge that sampled it.
- R5: With resend on, expiry raises `resend_o` together with the tag. The entry stays outstanding with its timer stopped and produces no further event. Issuing the same tag again restarts the full period.
- R6: With resend off, expiry raises `err_o` together with the tag and frees the tag. A later completion for that tag is unexpected.
- R7: While detection is disabled, no expiry strobe is produced and all countdowns hold. Issuing and completing tags still work. Once detection is re-enabled, counting resumes from the held value.
- R8: With `cap_ver2_i`=0, the enable, resend and period controls come from `ctl_disable_i`, `ctl_resend_i` and `ctl_period_i`. With `cap_ver2_i`=1, they come from `cfg_disable_i`, `rom_resend_i` and `cfg_period_i`, and the `ctl_*` inputs are ignored.
- R9: The status outputs show the effective controls one cycle after the selected source changes. A new period applies only to requests issued after that.
- R10: When several entries expire on the same tick, the block emits one strobe per cycle, lowest tag first, and loses none.
- R11: `resend_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request (or a retransmission) is sent this cycle |
| req_tag_i | input | TAG_W | Tag of the request |
| cpl_valid_i | input | 1 | A completion is received this cycle |
| cpl_tag_i | input | TAG_W | Tag of the completion |
| cap_ver2_i | input | 1 | Selects the second capability variant as the control source |
| ctl_disable_i | input | 1 | Control register: disable detection |
| ctl_resend_i | input | 1 | Control register: resend on expiry |
| ctl_period_i | input | PER_W | Control register: period code |
| cfg_disable_i | input | 1 | Configuration space: disable detection |
| cfg_period_i | input | PER_W | Configuration space: period code |
| rom_resend_i | input | 1 | Read-only resend bit loaded at initialization |
| resend_o | output | 1 | Resend strobe |
| resend_tag_o | output | TAG_W | Tag to resend |
| err_o | output | 1 | Timeout error strobe |
| err_tag_o | output | TAG_W | Tag that timed out |
| unexp_cpl_o | output | 1 | A completion matched no outstanding tag |
| sts_disable_o | output | 1 | Mirror of the effective disable control |
| sts_resend_o | output | 1 | Mirror of the effective resend control |
| sts_period_o | output | PER_W | Mirror of the effective period code |

## Verification
The bench checks each expiry against a window counted from the issue edge, for both a short and a long period code. A design that loads the wrong period, or counts raw cycles instead of ticks, lands outside that window.

It also probes the states that are easy to get wrong:
- An entry parked after a resend must stay silent until it is reissued. A design that keeps counting would fire twice.
- A late completion after an error must be flagged unexpected. A design that never frees the tag would stay quiet.
- Two entries frozen while detection is off and then released together must expire in back-to-back cycles, lowest tag first. A design that drops one of them fails this.
- Conflicting values are driven on the unselected control source. A design that picks the wrong source then shows the wrong mirrors and the wrong timing.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int PER_W = 2;

  typedef struct packed {
    logic             enable;
    logic             resend;
    logic [PER_W-1:0] period;
  } ctl_t;
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
  parameter int DIV = 16,
  localparam int CW = $clog2(DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == CW'(DIV - 1));
      cnt_q  <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tct_ctrl_sel.sv
module tct_ctrl_sel
  import tct_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_ver2_i,
  input  logic             ctl_disable_i,
  input  logic             ctl_resend_i,
  input  logic [PER_W-1:0] ctl_period_i,
  input  logic             cfg_disable_i,
  input  logic [PER_W-1:0] cfg_period_i,
  input  logic             rom_resend_i,
  output ctl_t             eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_o <= '{enable: 1'b1, resend: 1'b0, period: '0};
    end else if (cap_ver2_i) begin
      eff_o <= '{enable: !cfg_disable_i, resend: rom_resend_i, period: cfg_period_i};
    end else begin
      eff_o <= '{enable: !ctl_disable_i, resend: ctl_resend_i, period: ctl_period_i};
    end
  end
endmodule

// File: rtl/tct_entry.sv
module tct_entry #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             retire_i,
  input  logic             grant_i,
  input  logic             resend_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             valid_o,
  output logic             expired_o
);
  logic             park_q;  // expired, waiting for retransmission
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      park_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      park_q  <= 1'b0;
      cnt_q   <= period_i;
    end else if (retire_i) begin
      valid_o <= 1'b0;
      park_q  <= 1'b0;
    end else if (grant_i) begin
      if (resend_i) park_q <= 1'b1;
      else          valid_o <= 1'b0;
    end else if (tick_i && en_i && valid_o && !park_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = valid_o && !park_q && en_i && (cnt_q == '0);
endmodule

// File: rtl/cpl_timeout_tracker.sv
module cpl_timeout_tracker
  import tct_pkg::*;
#(
  parameter int NUM_TAGS   = 8,
  parameter int TICK_DIV   = 16,
  parameter int BASE_TICKS = 8,
  localparam int TAG_W = $clog2(NUM_TAGS),
  localparam int CNT_W = $clog2(BASE_TICKS << ((1 << PER_W) - 1)) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             cpl_valid_i,
  input  logic [TAG_W-1:0] cpl_tag_i,
  input  logic             cap_ver2_i,
  input  logic             ctl_disable_i,
  input  logic             ctl_resend_i,
  input  logic [PER_W-1:0] ctl_period_i,
  input  logic             cfg_disable_i,
  input  logic [PER_W-1:0] cfg_period_i,
  input  logic             rom_resend_i,
  output logic             resend_o,
  output logic [TAG_W-1:0] resend_tag_o,
  output logic             err_o,
  output logic [TAG_W-1:0] err_tag_o,
  output logic             unexp_cpl_o,
  output logic             sts_disable_o,
  output logic             sts_resend_o,
  output logic [PER_W-1:0] sts_period_o
);
  ctl_t                eff;
  logic                tick;
  logic [CNT_W-1:0]    period_ticks;
  logic [NUM_TAGS-1:0] load, retire, valid, expired, grant;
  logic [TAG_W-1:0]    gnt_tag;
  logic                gnt_any;

  tct_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  tct_ctrl_sel u_sel (
    .clk_i, .rst_ni, .cap_ver2_i, .ctl_disable_i, .ctl_resend_i, .ctl_period_i,
    .cfg_disable_i, .cfg_period_i, .rom_resend_i, .eff_o(eff)
  );

  assign period_ticks = CNT_W'(BASE_TICKS) << eff.period;

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_ent
    assign load[i]   = req_valid_i && (req_tag_i == TAG_W'(i));
    assign retire[i] = cpl_valid_i && (cpl_tag_i == TAG_W'(i)) && !load[i];

    tct_entry #(.CNT_W(CNT_W)) u_ent (
      .clk_i, .rst_ni,
      .load_i   (load[i]),
      .retire_i (retire[i]),
      .grant_i  (grant[i]),
      .resend_i (eff.resend),
      .tick_i   (tick),
      .en_i     (eff.enable),
      .period_i (period_ticks),
      .valid_o  (valid[i]),
      .expired_o(expired[i])
    );
  end

  // lowest tag wins; a handshake on the same tag this cycle takes precedence
  always_comb begin
    grant   = '0;
    gnt_tag = '0;
    gnt_any = 1'b0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (expired[i] && !load[i] && !retire[i] && !gnt_any) begin
        grant[i] = 1'b1;
        gnt_tag  = TAG_W'(i);
        gnt_any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resend_o     <= 1'b0;
      err_o        <= 1'b0;
      resend_tag_o <= '0;
      err_tag_o    <= '0;
      unexp_cpl_o  <= 1'b0;
    end else begin
      resend_o     <= gnt_any && eff.resend;
      err_o        <= gnt_any && !eff.resend;
      resend_tag_o <= gnt_tag;
      err_tag_o    <= gnt_tag;
      unexp_cpl_o  <= cpl_valid_i && !valid[cpl_tag_i];
    end
  end

  assign sts_disable_o = !eff.enable;
  assign sts_resend_o  = eff.resend;
  assign sts_period_o  = eff.period;
endmodule

// File: rtl/tct_checker.sv
module tct_checker
  import tct_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cap_ver2_i,
  input logic [PER_W-1:0] ctl_period_i,
  input logic             rom_resend_i,
  input logic             cpl_valid_i,
  input logic             resend_o,
  input logic             err_o,
  input logic             unexp_cpl_o,
  input logic             sts_disable_o,
  input logic             sts_resend_o,
  input logic [PER_W-1:0] sts_period_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resend_o && err_o));

  p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_disable_o |=> (!resend_o && !err_o));

  p_v1_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(cap_ver2_i)) |-> (sts_period_o == $past(ctl_period_i)));

  p_v2_resend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(cap_ver2_i)) |-> (sts_resend_o == $past(rom_resend_i)));

  p_unexp_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && unexp_cpl_o) |-> $past(cpl_valid_i));
endmodule

bind cpl_timeout_tracker tct_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cap_ver2_i   (cap_ver2_i),
  .ctl_period_i (ctl_period_i),
  .rom_resend_i (rom_resend_i),
  .cpl_valid_i  (cpl_valid_i),
  .resend_o     (resend_o),
  .err_o        (err_o),
  .unexp_cpl_o  (unexp_cpl_o),
  .sts_disable_o(sts_disable_o),
  .sts_resend_o (sts_resend_o),
  .sts_period_o (sts_period_o)
);

// File: tb/cpl_timeout_tracker_test.sv
`timescale 1ns/1ps
module cpl_timeout_tracker_test;
  localparam int DIV  = 16;
  localparam int BASE = 8;
  localparam int K_ERR = 0, K_RES = 1, K_UNX = 2;

  typedef struct {
    int    kind;
    int    tag;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, cpl_valid_i = 0, cap_ver2_i = 0;
  logic [2:0] req_tag_i = 0, cpl_tag_i = 0;
  logic ctl_disable_i = 0, ctl_resend_i = 0, cfg_disable_i = 0, rom_resend_i = 0;
  logic [1:0] ctl_period_i = 0, cfg_period_i = 0;
  logic resend_o, err_o, unexp_cpl_o, sts_disable_o, sts_resend_o;
  logic [2:0] resend_tag_o, err_tag_o;
  logic [1:0] sts_period_o;

  int checks = 0, errors = 0, cyc = 0;
  int err_cyc [8];
  exp_t q[$];

  cpl_timeout_tracker uut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_tag_i, .cpl_valid_i, .cpl_tag_i,
    .cap_ver2_i, .ctl_disable_i, .ctl_resend_i, .ctl_period_i, .cfg_disable_i,
    .cfg_period_i, .rom_resend_i, .resend_o, .resend_tag_o, .err_o, .err_tag_o,
    .unexp_cpl_o, .sts_disable_o, .sts_resend_o, .sts_period_o
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void push(int kind, int tag, int lo, int hi, string req);
    exp_t e;
    e.kind = kind; e.tag = tag; e.lo = lo; e.hi = hi; e.req = req;
    q.push_back(e);
  endfunction

  function automatic void observe(int kind, int tag);
    int idx = -1;
    for (int i = 0; i < q.size(); i++)
      if (idx < 0 && q[i].kind == kind && q[i].tag == tag) idx = i;
    checks++;
    if (idx < 0) begin
      errors++;
      $display("FAIL R3/R5: stray event kind %0d tag %0d at cycle %0d, actual 1 expected 0",
               kind, tag, cyc);
    end else begin
      if (cyc < q[idx].lo || cyc > q[idx].hi) begin
        errors++;
        $display("FAIL %s: kind %0d tag %0d at cycle %0d, expected within %0d..%0d",
                 q[idx].req, kind, tag, cyc, q[idx].lo, q[idx].hi);
      end
      q.delete(idx);
    end
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (err_o) begin
        observe(K_ERR, int'(err_tag_o));
        err_cyc[err_tag_o] = cyc;
      end
      if (resend_o)    observe(K_RES, int'(resend_tag_o));
      if (unexp_cpl_o) observe(K_UNX, int'(cpl_tag_q));
    end
  end

  logic [2:0] cpl_tag_q = 0;
  always @(posedge clk) if (cpl_valid_i) cpl_tag_q <= cpl_tag_i;

  // driver: issue a request; kind<0 means no expiry expected
  task automatic issue(int tag, int code, int kind, string req);
    int t, p;
    @(negedge clk);
    req_valid_i = 1; req_tag_i = 3'(tag);
    t = cyc + 1;
    p = BASE << code;
    if (kind >= 0) push(kind, tag, t + (p - 1) * DIV + 1, t + p * DIV + 2, req);
    @(negedge clk);
    req_valid_i = 0;
  endtask

  task automatic complete(int tag, bit unexp, string req);
    @(negedge clk);
    cpl_valid_i = 1; cpl_tag_i = 3'(tag);
    if (unexp) push(K_UNX, tag, cyc + 1, cyc + 2, req);
    @(negedge clk);
    cpl_valid_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(string req);
    int n = 0;
    while (q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    chk({req, " pending expectations"}, q.size(), 0);
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int en_edge;
    idle(5);
    rst_ni = 1;
    idle(2);
    // R1 reset state
    chk("R1 sts_disable", sts_disable_o, 0);
    chk("R1 sts_resend", sts_resend_o, 0);
    chk("R1 sts_period", sts_period_o, 0);
    chk("R1 strobes", {resend_o, err_o, unexp_cpl_o}, 0);

    // R2/R6: error on expiry, tag freed
    issue(2, 0, K_ERR, "R2");
    drain("R2");
    complete(2, 1, "R6");
    drain("R6");

    // R3/R4: completion retires, repeat completion is unexpected
    issue(5, 0, -1, "R3");
    idle(20);
    complete(5, 0, "R3");
    idle(300);
    complete(5, 1, "R4");
    drain("R4");

    // R5: resend, parked, reissue restarts
    ctl_resend_i = 1;
    idle(2);
    chk("R9 sts_resend follows ctl", sts_resend_o, 1);
    issue(1, 0, K_RES, "R5");
    drain("R5");
    idle(400);
    issue(1, 0, K_RES, "R5 reissue");
    drain("R5 reissue");
    complete(1, 0, "R5");
    idle(20);
    complete(1, 1, "R5 retired");
    drain("R5 retired");

    // R2 longer period code
    ctl_resend_i = 0; ctl_period_i = 2;
    idle(2);
    chk("R9 sts_period follows ctl", sts_period_o, 2);
    issue(4, 2, K_ERR, "R2 code2");
    drain("R2 code2");

    // R7 disable holds timers; R10 simultaneous expiry order
    ctl_period_i = 0; ctl_disable_i = 1;
    idle(2);
    chk("R9 sts_disable follows ctl", sts_disable_o, 1);
    issue(7, 0, -1, "R7");
    issue(0, 0, -1, "R7");
    issue(3, 0, -1, "R7");
    idle(10);
    complete(3, 0, "R7 retire while off");
    idle(400);
    complete(3, 1, "R7 retire while off");
    drain("R7");
    @(negedge clk);
    ctl_disable_i = 0;
    en_edge = cyc + 1;
    push(K_ERR, 0, en_edge + (BASE - 1) * DIV + 1, en_edge + BASE * DIV + 3, "R7 resume");
    push(K_ERR, 7, en_edge + (BASE - 1) * DIV + 1, en_edge + BASE * DIV + 4, "R7 resume");
    drain("R7 resume");
    chk("R10 tag7 one cycle after tag0", err_cyc[7] - err_cyc[0], 1);

    // R8 second variant: ctl inputs ignored
    cap_ver2_i = 1; cfg_disable_i = 0; cfg_period_i = 1; rom_resend_i = 0;
    ctl_disable_i = 1; ctl_resend_i = 1; ctl_period_i = 3;
    idle(2);
    chk("R8 v2 sts_disable", sts_disable_o, 0);
    chk("R8 v2 sts_resend", sts_resend_o, 0);
    chk("R8 v2 sts_period", sts_period_o, 1);
    issue(6, 1, K_ERR, "R8 v2 period");
    drain("R8 v2 period");
    rom_resend_i = 1;
    idle(2);
    chk("R8 v2 sts_resend from rom", sts_resend_o, 1);
    issue(6, 1, K_RES, "R8 v2 resend");
    drain("R8 v2 resend");
    complete(6, 0, "R8");
    cfg_disable_i = 1;
    idle(2);
    chk("R8 v2 sts_disable from cfg", sts_disable_o, 1);
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule